// File: doc/BRIEF.md
# Linear-Pointer SRAM Capture Buffer

This block sits between a bank of byte-wide asynchronous SRAM chips and a set of ADC channels on one side, and a serial-side consumer on the other. It never takes a random address. A single up-counting pointer walks the memory: a clear input puts it back at location zero, and each finished access moves it on by one. The low pointer bits drive the chip address pins. The bits just above them pick which chip, or which pair of chips, is selected.

The block has two modes, and only one is active at a time. In acquire mode each request stores one sample. The ADC channel that drives the shared data bus changes in turn, so the samples of several channels lie interleaved in memory. In download mode each request reads one location back, in the same order. The block remembers the last address written during acquire. Playback sets a done flag on the read of that address and then accepts no further reads. In acquire mode, writing the last location of the configured capacity raises a full flag. After that, further writes are refused, so stored data is never overwritten.

Each access takes three clocks: setup, strobe and hold. Address and select are set up one clock before the write or read strobe and stay valid for one clock after it. During a write the ADC output enable drives the bus. During a read the SRAM output enable drives it.

Top module: `seq_sram_capture`

## Requirements
- R1: While reset is held, and on the first clock after it, the pointer is zero. All `sram_cs_n` are high, `sram_we_n`, `sram_oe_n` and `adc_oe_n` are high, `adc_sel` is zero, and `buf_full` and `dl_done` are low.
- R2: An accepted write runs setup, strobe and hold, one clock each. In setup, select and address are driven with `sram_we_n` high. In strobe, `sram_we_n` is low. In hold, `sram_we_n` is high with select and address unchanged. After hold, all selects are released.
- R3: `sram_addr` always equals pointer bits [CHIP_AW-1:0]. At the end of every completed access, read or write, the pointer increases by exactly one.
- R4: With WIDE16=0, exactly one `sram_cs_n` bit is low during an access. Its index is pointer bits [CHIP_AW+1:CHIP_AW] (four chips).
- R5: With WIDE16=1, a location is one chip pair. Pointer bit CHIP_AW equal to p drives chips 2p and 2p+1 low together during an access.
- R6: Once the pointer reaches the capacity (chips times 2^CHIP_AW locations in 8-bit mode, half of that in 16-bit mode), `buf_full` is high. Acquire requests are then ignored and no chip is selected. `buf_full` falls on the next clear.
- R7: An accepted read drives `sram_oe_n` low in setup and strobe and raises `rd_strobe` in strobe only. `sram_we_n` stays high. Both enables are never low together.
- R8: `dl_done` rises at the end of the read whose address equals the last written address. It stays high until the next clear, and requests are ignored while it is high. A download clear with nothing captured sets `dl_done` at once.
- R9: During the setup and strobe of a write, `adc_oe_n` is low and `adc_sel` is one-hot for the current channel. The channel starts at 0 after a clear and steps 0,1,…,NUM_CH-1,0 with each completed write. While `solo_ch` is high at a write's end, the next channel is 0.
- R10: `ptr_clr` has priority. A request in the same clock is dropped. An access in flight is abandoned: all strobes and selects are inactive on the next clock, and the pointer is zero.
- R11: A clear with `mode_dl`=0 forgets the last written address. A clear with `mode_dl`=1 keeps it, so a download can be restarted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_clr | input | 1 | Clear pointer, start a mode |
| mode_dl | input | 1 | 0 = acquire, 1 = download |
| req | input | 1 | Request one access |
| solo_ch | input | 1 | Hold sampling on channel 0 |
| sram_addr | output | CHIP_AW | Chip address pins |
| sram_cs_n | output | NUM_CHIPS | Per-chip selects, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| adc_oe_n | output | 1 | ADC output enable, active low |
| adc_sel | output | NUM_CH | One-hot ADC channel select |
| rd_strobe | output | 1 | Read data valid for the consumer |
| buf_full | output | 1 | Capacity reached in acquire |
| dl_done | output | 1 | All captured data read back |

## Verification
Two pairs of events can fall in the same clock. A pointer clear can coincide with a request, or with the hold clock whose advance would move the pointer. A completing write can also coincide with the pointer reaching capacity. The bench holds `req` high through long runs and fires `ptr_clr` in setup, strobe and hold, both in directed steps and at random. A behavioural model, compared on every clock, judges the outcome: the clear wins and the advance and the channel step are lost. The fill runs end exactly at capacity in both bus widths. The next request there must select no chip.

// File: rtl/sram_cap_pkg.sv
package sram_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } acc_st_e;

  // number of independently selected banks (single chips or chip pairs)
  function automatic int unsigned banks_of(int unsigned chips, bit wide);
    return wide ? (chips / 2) : chips;
  endfunction

  // channel that follows the current one after a completed write
  function automatic int unsigned next_ch(int unsigned cur, int unsigned n, bit solo);
    if (solo) return 0;
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/sram_ptr_track.sv
module sram_ptr_track #(
  parameter int PTR_W = 24,
  parameter logic [PTR_W-1:0] CAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode_dl,
  input  logic             wr_done,
  input  logic             rd_done,
  output logic [PTR_W-1:0] ptr,
  output logic             full,
  output logic             done
);
  logic [PTR_W-1:0] last_q;
  logic             has_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      last_q <= '0;
      has_q  <= 1'b0;
      done   <= 1'b0;
    end else if (clr) begin
      ptr  <= '0;
      done <= mode_dl & ~has_q;
      if (!mode_dl) begin
        has_q  <= 1'b0;
        last_q <= '0;
      end
    end else begin
      if (wr_done) begin
        last_q <= ptr;
        has_q  <= 1'b1;
        ptr    <= ptr + 1'b1;
      end
      if (rd_done) begin
        ptr <= ptr + 1'b1;
        if (ptr == last_q) done <= 1'b1;
      end
    end
  end

  assign full = (ptr == CAP);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic mode_dl,
  input  logic full,
  input  logic done,
  output logic busy,
  output logic wr_done,
  output logic rd_done,
  output logic drive_acq,
  output logic we_n,
  output logic oe_n,
  output logic rd_strobe
);
  acc_st_e st_q;
  logic    op_rd_q;
  logic    go;
  logic    drive;

  assign go = (st_q == ST_IDLE) && req && (mode_dl ? !done : !full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_rd_q <= 1'b0;
    end else if (clr) begin
      st_q    <= ST_IDLE;
      op_rd_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q    <= ST_SETUP;
          op_rd_q <= mode_dl;
        end
        ST_SETUP:  st_q <= ST_STROBE;
        ST_STROBE: st_q <= ST_HOLD;
        ST_HOLD:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign drive     = (st_q == ST_SETUP) || (st_q == ST_STROBE);
  assign wr_done   = (st_q == ST_HOLD) && !op_rd_q;
  assign rd_done   = (st_q == ST_HOLD) && op_rd_q;
  assign drive_acq = drive && !op_rd_q;
  assign we_n      = !((st_q == ST_STROBE) && !op_rd_q);
  assign oe_n      = !(drive && op_rd_q);
  assign rd_strobe = (st_q == ST_STROBE) && op_rd_q;
endmodule

// File: rtl/sram_cs_dec.sv
module sram_cs_dec #(
  parameter int CHIP_AW   = 19,
  parameter int NUM_CHIPS = 4,
  parameter bit WIDE16    = 1'b0,
  parameter int BANK_W    = 2
) (
  input  logic [CHIP_AW+BANK_W-1:0] ptr_lo,
  input  logic                      en,
  output logic [CHIP_AW-1:0]        addr,
  output logic [NUM_CHIPS-1:0]      cs_n
);
  logic [BANK_W-1:0] bank;

  assign addr = ptr_lo[CHIP_AW-1:0];
  assign bank = ptr_lo[CHIP_AW +: BANK_W];

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_chip
    localparam int BANK_OF_K = WIDE16 ? (k / 2) : k;
    assign cs_n[k] = !(en && (bank == BANK_W'(BANK_OF_K)));
  end
endmodule

// File: rtl/adc_ch_pick.sv
module adc_ch_pick
  import sram_cap_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_done,
  input  logic            solo,
  output logic [CH_W-1:0] ch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ch <= '0;
    else if (clr)     ch <= '0;
    else if (wr_done) ch <= CH_W'(next_ch(int'(ch), NUM_CH, solo));
  end
endmodule

// File: rtl/seq_sram_capture.sv
module seq_sram_capture
  import sram_cap_pkg::*;
#(
  parameter int PTR_W       = 24,
  parameter int CHIP_AW     = 19,
  parameter int NUM_CHIPS   = 4,
  parameter bit WIDE16      = 1'b0,
  parameter int NUM_CH      = 2,
  parameter bit CH_FROM_PTR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_clr,
  input  logic                 mode_dl,
  input  logic                 req,
  input  logic                 solo_ch,
  output logic [CHIP_AW-1:0]   sram_addr,
  output logic [NUM_CHIPS-1:0] sram_cs_n,
  output logic                 sram_we_n,
  output logic                 sram_oe_n,
  output logic                 adc_oe_n,
  output logic [NUM_CH-1:0]    adc_sel,
  output logic                 rd_strobe,
  output logic                 buf_full,
  output logic                 dl_done
);
  localparam int BANKS  = banks_of(NUM_CHIPS, WIDE16);
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(BANKS) << CHIP_AW;

  // named internal events, also watched by the checker
  logic             busy;
  logic             wr_done;
  logic             rd_done;
  logic             adv_evt;
  logic             drive_acq;
  logic [PTR_W-1:0] ptr;
  logic [CH_W-1:0]  ch;

  assign adv_evt = wr_done | rd_done;

  sram_ptr_track #(.PTR_W(PTR_W), .CAP(CAP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .mode_dl(mode_dl),
    .wr_done(wr_done), .rd_done(rd_done),
    .ptr(ptr), .full(buf_full), .done(dl_done)
  );

  sram_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .req(req), .mode_dl(mode_dl),
    .full(buf_full), .done(dl_done), .busy(busy),
    .wr_done(wr_done), .rd_done(rd_done), .drive_acq(drive_acq),
    .we_n(sram_we_n), .oe_n(sram_oe_n), .rd_strobe(rd_strobe)
  );

  sram_cs_dec #(
    .CHIP_AW(CHIP_AW), .NUM_CHIPS(NUM_CHIPS), .WIDE16(WIDE16), .BANK_W(BANK_W)
  ) u_cs (
    .ptr_lo(ptr[CHIP_AW+BANK_W-1:0]), .en(busy),
    .addr(sram_addr), .cs_n(sram_cs_n)
  );

  if (CH_FROM_PTR) begin : g_ch_ptr
    // low pointer bits name the channel; NUM_CH must be a power of two
    assign ch = ptr[CH_W-1:0];
  end else begin : g_ch_cnt
    adc_ch_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .wr_done(wr_done),
      .solo(solo_ch), .ch(ch)
    );
  end

  assign adc_oe_n = !drive_acq;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign adc_sel[c] = drive_acq && (ch == CH_W'(c));
  end
endmodule

// File: rtl/sram_capture_chk.sv
module sram_capture_chk #(
  parameter int PTR_W     = 24,
  parameter int CHIP_AW   = 19,
  parameter int NUM_CHIPS = 4,
  parameter bit WIDE16    = 1'b0,
  parameter int NUM_CH    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ptr_clr,
  input logic                 sram_we_n,
  input logic                 sram_oe_n,
  input logic [NUM_CHIPS-1:0] sram_cs_n,
  input logic [CHIP_AW-1:0]   sram_addr,
  input logic [NUM_CH-1:0]    adc_sel,
  input logic                 adv_evt,
  input logic [PTR_W-1:0]     ptr,
  input logic                 buf_full,
  input logic                 dl_done
);
  p_setup_before_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (sram_cs_n != '1) && $stable(sram_cs_n) && $stable(sram_addr));

  p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && !$past(ptr_clr)) |-> (sram_cs_n != '1) && $stable(sram_addr));

  p_adv_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !ptr_clr) |=> (ptr == $past(ptr) + 1'b1));

  if (WIDE16) begin : g_pair
    p_pair_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~sram_cs_n) == 0) || ($countones(~sram_cs_n) == 2));
  end else begin : g_single
    p_one_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sram_cs_n));
  end

  p_full_no_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> (sram_cs_n == '1));

  p_enables_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_done && !ptr_clr) |=> dl_done);

  p_adc_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_sel));

  p_clr_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (sram_cs_n == '1) && sram_we_n && sram_oe_n && (ptr == '0));
endmodule

bind seq_sram_capture sram_capture_chk #(
  .PTR_W(PTR_W), .CHIP_AW(CHIP_AW), .NUM_CHIPS(NUM_CHIPS),
  .WIDE16(WIDE16), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_cs_n(sram_cs_n),
  .sram_addr(sram_addr), .adc_sel(adc_sel), .adv_evt(adv_evt),
  .ptr(ptr), .buf_full(buf_full), .dl_done(dl_done)
);

// File: tb/seq_sram_capture_tb.sv
module seq_sram_capture_tb;
  localparam int CAW = 4;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_clr = 1'b0, mode_dl = 1'b0, req = 1'b0, solo_ch = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  logic [CAW-1:0] addr8, addr16;
  logic [3:0]     cs8, cs16;
  logic           we8, we16, oe8, oe16, aoe8, aoe16, rs8, rs16, full8, full16, done8, done16;
  logic [NCH-1:0] sel8, sel16;

  seq_sram_capture #(.CHIP_AW(CAW), .WIDE16(1'b0), .NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .mode_dl(mode_dl), .req(req),
    .solo_ch(solo_ch), .sram_addr(addr8), .sram_cs_n(cs8), .sram_we_n(we8),
    .sram_oe_n(oe8), .adc_oe_n(aoe8), .adc_sel(sel8), .rd_strobe(rs8),
    .buf_full(full8), .dl_done(done8));

  seq_sram_capture #(.CHIP_AW(CAW), .WIDE16(1'b1), .NUM_CH(NCH)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .mode_dl(mode_dl), .req(req),
    .solo_ch(solo_ch), .sram_addr(addr16), .sram_cs_n(cs16), .sram_we_n(we16),
    .sram_oe_n(oe16), .adc_oe_n(aoe16), .adc_sel(sel16), .rd_strobe(rs16),
    .buf_full(full16), .dl_done(done16));

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // behavioural reference: index 0 = byte-wide build, 1 = pair build
  int m_ptr[2], m_st[2], m_op[2], m_last[2], m_has[2], m_done[2], m_ch[2];

  function automatic int cap_of(int i); return i ? 32 : 64; endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_ptr[i] = 0; m_st[i] = 0; m_op[i] = 0; m_last[i] = 0;
        m_has[i] = 0; m_done[i] = 0; m_ch[i] = 0;
      end else if (ptr_clr) begin
        m_ptr[i] = 0; m_st[i] = 0; m_op[i] = 0; m_ch[i] = 0;
        m_done[i] = (mode_dl && !m_has[i]) ? 1 : 0;
        if (!mode_dl) begin m_has[i] = 0; m_last[i] = 0; end
      end else begin
        case (m_st[i])
          0: if (req && (mode_dl ? !m_done[i] : (m_ptr[i] != cap_of(i)))) begin
               m_st[i] = 1; m_op[i] = mode_dl;
             end
          1: m_st[i] = 2;
          2: m_st[i] = 3;
          default: begin
            m_st[i] = 0;
            if (m_op[i] == 0) begin
              m_last[i] = m_ptr[i]; m_has[i] = 1;
              m_ch[i] = solo_ch ? 0 : (m_ch[i] + 1) % NCH;
            end else if (m_ptr[i] == m_last[i]) m_done[i] = 1;
            m_ptr[i] = m_ptr[i] + 1;
          end
        endcase
      end
    end
  end

  task automatic chk(string tag, string sig, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, sig, act, exp, $time);
    end
  endtask

  function automatic int exp_cs(int i);
    int bank, r;
    r = 15;
    if (m_st[i] != 0) begin
      bank = (m_ptr[i] >> CAW) % (i ? 2 : 4);
      for (int k = 0; k < 4; k++)
        if ((i ? k / 2 : k) == bank) r &= ~(1 << k);
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      for (int i = 0; i < 2; i++) begin
        bit drv;
        drv = (m_st[i] == 1) || (m_st[i] == 2);
        chk("R3", "sram_addr", i ? int'(addr16) : int'(addr8), m_ptr[i] % 16);
        chk(i ? "R5" : "R4", "sram_cs_n", i ? int'(cs16) : int'(cs8), exp_cs(i));
        chk("R2", "sram_we_n", i ? int'(we16) : int'(we8), (m_st[i] == 2 && m_op[i] == 0) ? 0 : 1);
        chk("R7", "sram_oe_n", i ? int'(oe16) : int'(oe8), (drv && m_op[i] == 1) ? 0 : 1);
        chk("R7", "rd_strobe", i ? int'(rs16) : int'(rs8), (m_st[i] == 2 && m_op[i] == 1) ? 1 : 0);
        chk("R9", "adc_oe_n", i ? int'(aoe16) : int'(aoe8), (drv && m_op[i] == 0) ? 0 : 1);
        chk("R9", "adc_sel", i ? int'(sel16) : int'(sel8), (drv && m_op[i] == 0) ? (1 << m_ch[i]) : 0);
        chk("R6", "buf_full", i ? int'(full16) : int'(full8), (m_ptr[i] == cap_of(i)) ? 1 : 0);
        chk("R8", "dl_done", i ? int'(done16) : int'(done8), m_done[i]);
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_clr(bit dl);
    @(negedge clk); ptr_clr = 1'b1; mode_dl = dl;
    @(negedge clk); ptr_clr = 1'b0;
  endtask

  initial begin
    cyc(3);
    // R1: reset state seen at the ports
    chk("R1", "cs_n idle", int'(cs8), 15);
    chk("R1", "we_n/oe_n", int'({we8, oe8, aoe8}), 7);
    chk("R1", "full/done", int'({full8, done8, full16, done16}), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "after release cs_n", int'(cs16), 15);

    // acquire: back-to-back writes, channel rotation, then solo
    do_clr(1'b0);
    req = 1'b1; cyc(40);
    solo_ch = 1'b1; cyc(16); solo_ch = 1'b0;
    // R10: clear with a request in the same clock, mid-access
    ptr_clr = 1'b1; cyc(1); ptr_clr = 1'b0;
    chk("R10", "cs_n after clear", int'(cs8), 15);
    chk("R10", "addr after clear", int'(addr8), 0);
    // fill both builds to capacity and keep requesting
    cyc(300);
    chk("R6", "full at capacity 8-bit", int'(full8), 1);
    chk("R6", "full at capacity 16-bit", int'(full16), 1);
    chk("R6", "no select when full", int'(cs8), 15);
    req = 1'b0;

    // download everything back, then restart it (R11)
    do_clr(1'b1);
    chk("R11", "done low after download clear", int'(done8), 0);
    req = 1'b1; cyc(300);
    chk("R8", "done after playback 8-bit", int'(done8), 1);
    chk("R8", "done after playback 16-bit", int'(done16), 1);
    do_clr(1'b1);
    chk("R11", "restart keeps data", int'(done8), 0);
    cyc(10);
    // R10: abort a read in flight
    ptr_clr = 1'b1; cyc(1); ptr_clr = 1'b0;
    chk("R10", "oe_n after abort", int'(oe8), 1);
    req = 1'b0;

    // R8/R11: acquire clear forgets data; empty download is done at once
    do_clr(1'b0);
    do_clr(1'b1);
    chk("R8", "empty download done", int'(done8), 1);
    chk("R11", "empty download done 16-bit", int'(done16), 1);

    // random phase
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      req = ($urandom_range(0, 9) < 7);
      solo_ch = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 59) == 0) begin
        ptr_clr = 1'b1; mode_dl = $urandom_range(0, 1);
      end else ptr_clr = 1'b0;
    end
    ptr_clr = 1'b0; req = 1'b0;
    cyc(4);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule